// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit is a 64-bit execution slice for the bit-field instruction group. It takes an already decoded 6-bit function code, a source operand, the current value of the destination register and two 5-bit immediates. One immediate is the low bit position. The other is either the field length minus one (extract) or the top bit position (insert). The unit returns the new destination value, a write enable and an illegal-operation flag.

Four extract forms and four insert forms are decoded. Some of them add 32 to a position or to a width, so that a field can reach into the upper word. The two 32-bit forms work on the low word and sign-extend their result from bit 31. A 64-bit-mode enable gates the doubleword forms. The register file, fetch and full instruction decode sit outside the block.

All three results are registered and appear one clock after a valid input pulse. Reset is synchronous and active-low.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `wr_en` and `illegal` become 0 and `result` becomes all zeros after that edge.
- R2: A cycle with `in_valid` high gives `out_valid` high exactly one clock later. A cycle with `in_valid` low gives `out_valid`, `wr_en` and `illegal` all low one clock later.
- R3: Function 6'b000011 (doubleword extract) returns `hi_f+1` bits of `src` starting at bit `lsb_f`, placed at bit 0, with zeros above the field.
- R4: Function 6'b000001 extracts like R3 but with a field width of `hi_f+33`.
- R5: Function 6'b000010 extracts like R3 but starting at bit `lsb_f+32`.
- R6: Function 6'b000000 (word extract) takes `hi_f+1` bits of `src[31:0]` from bit `lsb_f`, with zeros above the field. It then sign-extends bit 31 into bits 63:32.
- R7: Function 6'b000111 (doubleword insert) replaces bits `hi_f` down to `lsb_f` of `dst_in` with the low-order bits of `src`. All other bits of `dst_in` are kept.
- R8: Function 6'b000101 inserts like R7 with a top bit of `hi_f+32`.
- R9: Function 6'b000110 inserts like R7 with a low bit of `lsb_f+32` and a top bit of `hi_f+32`.
- R10: Function 6'b000100 (word insert) inserts like R7 into `dst_in[31:0]`. It then sign-extends bit 31 of the merged word into bits 63:32.
- R11: An insert whose effective low bit is above its effective top bit returns `dst_in` unchanged, with `wr_en` high.
- R12: With `mode64_en` low, functions 000001, 000010, 000011, 000101, 000110 and 000111 give `illegal`=1, `wr_en`=0 and `result`=0. Functions 000000 and 000100 still execute normally.
- R13: Any function code outside the eight listed gives `illegal`=1, `wr_en`=0 and `result`=0, whatever the state of `mode64_en`.
- R14: Field bits that would land above bit 63 (above bit 31 for the word forms) are dropped. Source bits read from beyond the top of the operand count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| func | input | 6 | Decoded function code |
| src | input | 64 | Source operand |
| dst_in | input | 64 | Current destination value |
| lsb_f | input | 5 | Low bit position immediate |
| hi_f | input | 5 | Length-minus-one or top bit immediate |
| mode64_en | input | 1 | Enables doubleword forms |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | New destination value |
| wr_en | output | 1 | Destination write enable |
| illegal | output | 1 | Illegal-operation flag |

## Verification
The checker assumes that `func`, the immediates, `dst_in` and `mode64_en` are known and stable at every clock edge where `in_valid` is high. It also assumes that reset is held for at least one edge before the first operation. The bench changes inputs only on the falling clock edge, and it drives defined values on every input from time zero. It keeps reset low for several cycles before the first pulse. The bench mixes back-to-back pulses with idle gaps, so that both branches of the latency property are exercised.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  parameter int XLEN  = 64;
  parameter int HLEN  = XLEN / 2;
  parameter int IMM_W = 5;
  parameter int FN_W  = 6;
  localparam int POS_W = $clog2(XLEN) + 1;

  typedef struct packed {
    logic             known;
    logic             needs64;
    logic             is_ins;
    logic             is_w32;
    logic [POS_W-1:0] pos_a;   // start (extract) or low bit (insert)
    logic [POS_W-1:0] pos_b;   // width (extract) or top bit (insert)
  } bfu_ctrl_t;

  function automatic logic [XLEN-1:0] bf_extract(input logic [XLEN-1:0] v,
                                                 input logic [POS_W-1:0] start,
                                                 input logic [POS_W-1:0] width);
    logic [XLEN-1:0] m;
    m = width[POS_W-1] ? '1 : ((XLEN'(1) << width[POS_W-2:0]) - XLEN'(1));
    return (v >> start[POS_W-2:0]) & m;
  endfunction

  function automatic logic [XLEN-1:0] bf_insert(input logic [XLEN-1:0] dst,
                                                input logic [XLEN-1:0] v,
                                                input logic [POS_W-1:0] lo,
                                                input logic [POS_W-1:0] hi);
    logic [XLEN-1:0] m;
    logic [POS_W-2:0] top_gap;
    top_gap = (POS_W-1)'(XLEN - 1) - hi[POS_W-2:0];
    m = ({XLEN{1'b1}} << lo[POS_W-2:0]) & ({XLEN{1'b1}} >> top_gap);
    return (dst & ~m) | ((v << lo[POS_W-2:0]) & m);
  endfunction

  function automatic logic [XLEN-1:0] sext_half(input logic [XLEN-1:0] v);
    return {{HLEN{v[HLEN-1]}}, v[HLEN-1:0]};
  endfunction
endpackage

// File: rtl/bfu_decode.sv
module bfu_decode
  import bfu_pkg::*;
(
  input  logic [FN_W-1:0]  func,
  input  logic [IMM_W-1:0] lsb_f,
  input  logic [IMM_W-1:0] hi_f,
  output bfu_ctrl_t        ctrl,
  output logic             inverted
);
  localparam logic [POS_W-1:0] OFS = POS_W'(HLEN);
  logic [POS_W-1:0] lo_z, hi_z;

  assign lo_z = POS_W'(lsb_f);
  assign hi_z = POS_W'(hi_f);

  always_comb begin
    ctrl = '0;
    ctrl.known = 1'b1;
    unique case (func)
      6'b000000: begin ctrl.is_w32 = 1'b1; ctrl.pos_a = lo_z; ctrl.pos_b = hi_z + 1'b1; end
      6'b000011: begin ctrl.needs64 = 1'b1; ctrl.pos_a = lo_z; ctrl.pos_b = hi_z + 1'b1; end
      6'b000001: begin ctrl.needs64 = 1'b1; ctrl.pos_a = lo_z; ctrl.pos_b = hi_z + OFS + 1'b1; end
      6'b000010: begin ctrl.needs64 = 1'b1; ctrl.pos_a = lo_z + OFS; ctrl.pos_b = hi_z + 1'b1; end
      6'b000100: begin ctrl.is_ins = 1'b1; ctrl.is_w32 = 1'b1; ctrl.pos_a = lo_z; ctrl.pos_b = hi_z; end
      6'b000111: begin ctrl.is_ins = 1'b1; ctrl.needs64 = 1'b1; ctrl.pos_a = lo_z; ctrl.pos_b = hi_z; end
      6'b000101: begin ctrl.is_ins = 1'b1; ctrl.needs64 = 1'b1; ctrl.pos_a = lo_z; ctrl.pos_b = hi_z + OFS; end
      6'b000110: begin ctrl.is_ins = 1'b1; ctrl.needs64 = 1'b1; ctrl.pos_a = lo_z + OFS; ctrl.pos_b = hi_z + OFS; end
      default:   ctrl.known = 1'b0;
    endcase
  end

  assign inverted = ctrl.is_ins && (ctrl.pos_a > ctrl.pos_b);
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
(
  input  bfu_ctrl_t       ctrl,
  input  logic            inverted,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] dst_in,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] src_lo, dst_lo, ext_full, ext_half, ins_full, ins_half;

  assign src_lo = {{HLEN{1'b0}}, src[HLEN-1:0]};
  assign dst_lo = {{HLEN{1'b0}}, dst_in[HLEN-1:0]};

  assign ext_full = bf_extract(src, ctrl.pos_a, ctrl.pos_b);
  assign ext_half = sext_half(bf_extract(src_lo, ctrl.pos_a, ctrl.pos_b));
  assign ins_full = bf_insert(dst_in, src, ctrl.pos_a, ctrl.pos_b);
  assign ins_half = sext_half(bf_insert(dst_lo, src, ctrl.pos_a, ctrl.pos_b));

  always_comb begin
    if (!ctrl.is_ins)   res = ctrl.is_w32 ? ext_half : ext_full;
    else if (inverted)  res = dst_in;
    else                res = ctrl.is_w32 ? ins_half : ins_full;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FN_W-1:0]  func,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  dst_in,
  input  logic [IMM_W-1:0] lsb_f,
  input  logic [IMM_W-1:0] hi_f,
  input  logic             mode64_en,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             wr_en,
  output logic             illegal
);
  bfu_ctrl_t       ctrl;
  logic            ins_inverted;
  logic            dec_illegal;
  logic [XLEN-1:0] res_comb;

  bfu_decode u_dec (
    .func(func), .lsb_f(lsb_f), .hi_f(hi_f),
    .ctrl(ctrl), .inverted(ins_inverted)
  );

  bfu_datapath u_dp (
    .ctrl(ctrl), .inverted(ins_inverted),
    .src(src), .dst_in(dst_in), .res(res_comb)
  );

  assign dec_illegal = !ctrl.known || (ctrl.needs64 && !mode64_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && !dec_illegal;
      illegal   <= in_valid && dec_illegal;
      if (in_valid) result <= dec_illegal ? '0 : res_comb;
    end
  end
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker
  import bfu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [FN_W-1:0]  func,
  input logic [XLEN-1:0]  dst_in,
  input logic             mode64_en,
  input logic             dec_illegal,
  input logic             ins_inverted,
  input logic             out_valid,
  input logic [XLEN-1:0]  result,
  input logic             wr_en,
  input logic             illegal
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !wr_en && !illegal && result == '0));

  assert_pulse_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en && !illegal));

  assert_word_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func == 6'b000000) |=> (result[XLEN-1:HLEN] == {HLEN{result[HLEN-1]}}));

  assert_keep_on_inverted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ins_inverted && !dec_illegal) |=> (wr_en && result == $past(dst_in)));

  assert_mode_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode64_en && func inside {6'b000001, 6'b000010, 6'b000011,
                                            6'b000101, 6'b000110, 6'b000111})
    |=> (illegal && !wr_en && result == '0));

  assert_unknown_fn_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func[5:3] != 3'b000) |=> (illegal && !wr_en && result == '0));

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({wr_en, illegal}));
endmodule

bind bitfield_unit bfu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func),
  .dst_in(dst_in), .mode64_en(mode64_en), .dec_illegal(dec_illegal),
  .ins_inverted(ins_inverted), .out_valid(out_valid), .result(result),
  .wr_en(wr_en), .illegal(illegal)
);

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  func = '0;
  logic [63:0] src = '0;
  logic [63:0] dst_in = '0;
  logic [4:0]  lsb_f = '0;
  logic [4:0]  hi_f = '0;
  logic        mode64_en = 1'b1;
  logic        out_valid, wr_en, illegal;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [63:0] res;
    logic        wr;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  bitfield_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func), .src(src),
    .dst_in(dst_in), .lsb_f(lsb_f), .hi_f(hi_f), .mode64_en(mode64_en),
    .out_valid(out_valid), .result(result), .wr_en(wr_en), .illegal(illegal)
  );

  // Reference: walks bit by bit from the requirement text.
  function automatic exp_t model(input logic [5:0] f, input logic [63:0] s,
                                 input logic [63:0] d, input int lo, input int hf,
                                 input logic m64, input string tag);
    exp_t e;
    int start, width, top, lim;
    bit ins, w32, wide, ok;
    logic [63:0] r;
    ok = 1; ins = 0; w32 = 0; wide = 1;
    start = lo; width = hf + 1; top = hf;
    case (f)
      6'b000000: begin w32 = 1; wide = 0; end
      6'b000011: ;
      6'b000001: width = hf + 33;
      6'b000010: start = lo + 32;
      6'b000100: begin ins = 1; w32 = 1; wide = 0; end
      6'b000111: ins = 1;
      6'b000101: begin ins = 1; top = hf + 32; end
      6'b000110: begin ins = 1; start = lo + 32; top = hf + 32; end
      default: ok = 0;
    endcase
    e.tag = tag;
    if (!ok || (wide && !m64)) begin
      e.res = '0; e.wr = 0; e.ill = 1;
      return e;
    end
    e.wr = 1; e.ill = 0;
    lim = w32 ? 32 : 64;
    if (!ins) begin
      r = '0;
      for (int i = 0; i < 64; i++)
        if (i < width && start + i < lim) r[i] = s[start + i];
    end else if (start > top) begin
      r = d;
    end else begin
      r = d;
      for (int p = start; p <= top; p++)
        if (p < lim) r[p] = s[p - start];
    end
    if (w32 && !(ins && start > top))
      for (int i = 32; i < 64; i++) r[i] = r[31];
    e.res = r;
    return e;
  endfunction

  task automatic drive(input logic [5:0] f, input logic [63:0] s, input logic [63:0] d,
                       input int lo, input int hf, input logic m64, input string tag);
    @(negedge clk);
    func = f; src = s; dst_in = d; lsb_f = lo[4:0]; hi_f = hf[4:0];
    mode64_en = m64; in_valid = 1'b1;
    sb.push_back(model(f, s, d, lo, hf, m64, tag));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: out_valid=1 with nothing outstanding, expected out_valid=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (result !== e.res || wr_en !== e.wr || illegal !== e.ill) begin
          fails++;
          $display("FAIL %s: result=%h wr=%b ill=%b expected result=%h wr=%b ill=%b",
                   e.tag, result, wr_en, illegal, e.res, e.wr, e.ill);
        end
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  localparam logic [63:0] SA = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] SB = 64'h8000_00A5_C3F0_0F5A;
  localparam logic [63:0] DA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] DB = 64'h5555_AAAA_3333_CCCC;

  initial begin
    repeat (4) @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || illegal !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R1: valid=%b wr=%b ill=%b result=%h expected all zero",
               out_valid, wr_en, illegal, result);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 idle quiet after reset release
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || illegal !== 1'b0) begin
      fails++;
      $display("FAIL R2: idle valid=%b wr=%b ill=%b expected 0 0 0", out_valid, wr_en, illegal);
    end

    drive(6'b000011, SA, DA, 4, 7, 1, "R3 dword extract");
    drive(6'b000011, SA, DA, 0, 31, 1, "R3 dword extract at bit 0");
    drive(6'b000011, SA, DA, 31, 31, 1, "R3 dword extract high reach");
    drive(6'b000001, SA, DA, 8, 20, 1, "R4 widened extract");
    drive(6'b000001, SB, DA, 31, 31, 1, "R14 widened extract past top");
    drive(6'b000010, SA, DA, 0, 31, 1, "R5 upper-start extract");
    drive(6'b000010, SB, DA, 28, 7, 1, "R14 upper-start extract past top");
    drive(6'b000000, SB, DA, 24, 7, 1, "R6 word extract sign set");
    drive(6'b000000, SA, DA, 4, 7, 1, "R6 word extract positive");
    drive(6'b000000, SB, DA, 28, 15, 1, "R6 R14 word extract clipped at 31");
    idle(1);
    checks++;  // R2 one idle cycle after a burst
    @(negedge clk);
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2: out_valid=%b after gap, expected 0", out_valid);
    end

    drive(6'b000111, SA, DA, 8, 23, 1, "R7 dword insert");
    drive(6'b000111, SB, DB, 0, 31, 1, "R7 dword insert low word");
    drive(6'b000101, SA, DA, 20, 10, 1, "R8 insert top+32");
    drive(6'b000101, SB, DB, 31, 31, 1, "R8 R14 insert top+32 high lsb");
    drive(6'b000110, SA, DA, 4, 11, 1, "R9 upper insert");
    drive(6'b000110, SB, DB, 0, 31, 1, "R9 upper insert full word");
    drive(6'b000100, SB, DA, 16, 31, 1, "R10 word insert sign set");
    drive(6'b000100, SA, DB, 0, 7, 1, "R10 word insert positive");
    drive(6'b000111, SA, DA, 20, 5, 1, "R11 dword insert inverted");
    drive(6'b000110, SA, DB, 9, 3, 1, "R11 upper insert inverted");
    drive(6'b000100, SA, DA, 31, 0, 1, "R11 word insert inverted");
    drive(6'b000011, SA, DA, 4, 7, 0, "R12 dword extract gated");
    drive(6'b000110, SA, DA, 4, 11, 0, "R12 upper insert gated");
    drive(6'b000000, SB, DA, 24, 7, 0, "R12 word extract allowed");
    drive(6'b000100, SB, DA, 16, 31, 0, "R12 word insert allowed");
    drive(6'b001000, SA, DA, 1, 2, 1, "R13 unknown code");
    drive(6'b111111, SA, DA, 1, 2, 0, "R13 unknown code mode off");
    idle(3);
    checks++;  // R2 nothing left outstanding
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results missing, expected 0", sb.size());
    end
    summary();
    $finish;
  end
endmodule